// File: doc/BRIEF.md
# OFDM frame timing scheduler

This block is the time base of a downlink OFDM transmitter. A sample counter of programmable length drives a cascade of counters that give the sample position inside a symbol, the symbol inside a slot (14), the slot inside a subframe (2), the subframe inside a frame (10) and the frame number (1024 by default). Each counter boundary also produces a one-cycle strobe. A flag marks the first symbol of every slot, which is the symbol that needs the longer cyclic prefix.

The same time base decides where synchronization blocks go. A burst of eight four-symbol blocks is sent only in even-numbered frames. A small state machine tracks the symbol number within the frame and reports three things: whether a block is on air, which of the eight blocks it is, and a modulo-960 write address for the buffer that holds the block's 4 × 240 samples. The state machine has three states. SS_OFF_FRAME covers odd frames. SS_GAP covers even-frame symbols outside any block. SS_BLOCK covers symbols inside a block. The named transitions are:
- burst-frame entry (OFF_FRAME→GAP or →BLOCK)
- block start (GAP→BLOCK)
- block end (BLOCK→GAP)
- next block (BLOCK→BLOCK with a new index)
- frame leave (any state→OFF_FRAME)

Every output is registered and is updated on the same clock edge as the counters. The symbol length should only be changed while reset is held or at a symbol boundary.

Top module: `ofdm_frame_timer`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, every index, `ss_idx` and `buf_addr` read 0, and every strobe and `ss_active` read 0.
- R2: `sample_idx` counts enabled cycles from 0 to `sym_len`−1 and then returns to 0. A `sym_len` of 0 means the full 4096 samples (wrap after 4095). Each wrap advances `sym_idx`.
- R3: Each index wraps at its own limit and carries into the next one: `sym_idx` at 14 into `slot_idx`, `slot_idx` at 2 into `subframe_idx`, `subframe_idx` at 10 into `frame_idx`. `frame_idx` wraps at NUM_FRAMES.
- R4: `sym_tick`, `slot_tick`, `subframe_tick` and `frame_tick` are each high for exactly the one cycle in which the outputs first show sample 0 of a new symbol, slot, subframe or frame. No strobe fires at reset.
- R5: `first_sym` is high in exactly those cycles where `sym_idx` is 0.
- R6: While `en` is low, no index, no decoder output and no address changes, and every strobe stays low.
- R7: `ss_active` is high exactly when `frame_idx` is even and the frame symbol number (subframe×28 + slot×14 + symbol) lies in [s, s+3] for some s in {4, 8, 16, 20, 32, 36, 44, 48}.
- R8: While `ss_active` is high, `ss_idx` gives the ordinal 0 to 7 of the block whose start s holds the current symbol, in the order listed in R7. Otherwise `ss_idx` reads 0.
- R9: `buf_addr` reads 0 in the first cycle of each block and rises by one on every enabled cycle inside the block. It wraps from 959 back to 0 and reads 0 whenever `ss_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance enable, one sample per cycle |
| sym_len | input | SAMPLE_W (12) | Samples per symbol; 0 selects 2^SAMPLE_W |
| sample_idx | output | SAMPLE_W (12) | Sample position in the symbol |
| sym_idx | output | 4 | Symbol in slot, 0..13 |
| slot_idx | output | 1 | Slot in subframe, 0..1 |
| subframe_idx | output | 4 | Subframe in frame, 0..9 |
| frame_idx | output | FRAME_W (10) | Frame number |
| sym_tick | output | 1 | New-symbol strobe |
| slot_tick | output | 1 | New-slot strobe |
| subframe_tick | output | 1 | New-subframe strobe |
| frame_tick | output | 1 | New-frame strobe |
| first_sym | output | 1 | First symbol of slot (long cyclic prefix) |
| ss_active | output | 1 | A synchronization block is on air |
| ss_idx | output | 3 | Block ordinal within the burst |
| buf_addr | output | 10 | Block buffer write address, modulo 960 |

## Verification
The bench aims at the symbols where two blocks abut (7→8, 19→20, 35→36, 47→48). A decoder that did not spot the next-block transition there would leave `buf_addr` running instead of clearing it, or would keep the old `ss_idx`. It checks the odd frame and the return to frame 0 after the last frame. A design with the parity wrong would send a burst one frame in two at the wrong time, or would drop the burst after the frame wrap. It also covers a zero symbol length with the address wrap at 959, and a hold of `en` at a symbol boundary. A design with an off-by-one limit or a strobe that ignores enable would slip the whole cascade or pulse a strobe while frozen.

// File: rtl/ofdm_timer_pkg.sv
package ofdm_timer_pkg;

    typedef enum logic [1:0] {
        SS_OFF_FRAME = 2'd0,
        SS_GAP       = 2'd1,
        SS_BLOCK     = 2'd2
    } ss_state_e;

    // Start symbol of block k inside a frame: blocks come in pairs, the
    // pairs sit in successive slots, alternating offsets 4 and 2 within
    // the slot, with the second block of each pair four symbols later.
    function automatic int unsigned blk_start(int unsigned k, int unsigned sps);
        int unsigned pair;
        pair = k >> 1;
        return pair * sps + (((pair & 1) != 0) ? 2 : 4) + 4 * (k & 1);
    endfunction

endpackage

// File: rtl/ofdm_wrap_counter.sv
module ofdm_wrap_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    // ">=" keeps a count that sits above a freshly lowered limit from
    // running through the whole range before it wraps.
    assign wrap = inc && (cnt >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            if (cnt >= last) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ofdm_count_chain.sv
module ofdm_count_chain #(
    parameter int SAMPLE_W   = 12,
    parameter int SPS        = 14,
    parameter int SLOTS      = 2,
    parameter int SFS        = 10,
    parameter int NUM_FRAMES = 1024,
    parameter int SYM_W      = 4,
    parameter int SLOT_W     = 1,
    parameter int SF_W       = 4,
    parameter int FRAME_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sym_len,
    output logic [SAMPLE_W-1:0] sample_cnt,
    output logic [SYM_W-1:0]    sym_cnt,
    output logic [SLOT_W-1:0]   slot_cnt,
    output logic [SF_W-1:0]     sf_cnt,
    output logic [FRAME_W-1:0]  frame_cnt,
    output logic [3:0]          ticks,
    output logic                sym_adv,
    output logic                frame_even_nxt
);

    // carry[0]: symbol advance, carry[1]: slot advance,
    // carry[2]: subframe advance, carry[3]: frame advance
    logic [3:0] carry;
    logic       frame_wrap;

    ofdm_wrap_counter #(.W(SAMPLE_W)) u_sample (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (en),
        .last  (sym_len - 1'b1),
        .cnt   (sample_cnt),
        .wrap  (carry[0])
    );

    ofdm_wrap_counter #(.W(SYM_W)) u_sym (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (carry[0]),
        .last  (SYM_W'(SPS - 1)),
        .cnt   (sym_cnt),
        .wrap  (carry[1])
    );

    ofdm_wrap_counter #(.W(SLOT_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (carry[1]),
        .last  (SLOT_W'(SLOTS - 1)),
        .cnt   (slot_cnt),
        .wrap  (carry[2])
    );

    ofdm_wrap_counter #(.W(SF_W)) u_sf (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (carry[2]),
        .last  (SF_W'(SFS - 1)),
        .cnt   (sf_cnt),
        .wrap  (carry[3])
    );

    ofdm_wrap_counter #(.W(FRAME_W)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (carry[3]),
        .last  (FRAME_W'(NUM_FRAMES - 1)),
        .cnt   (frame_cnt),
        .wrap  (frame_wrap)
    );

    assign sym_adv = carry[0];

    // Parity of the frame number after this edge: frame+1 is even when the
    // current frame is odd, and a wrap always lands on frame 0.
    assign frame_even_nxt = carry[3] ? (frame_wrap | frame_cnt[0]) : ~frame_cnt[0];

    // A strobe is high in the first cycle that shows the new unit.
    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_tick
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ticks[g] <= 1'b0;
                else        ticks[g] <= carry[g];
            end
        end
    endgenerate

endmodule

// File: rtl/ofdm_ss_decoder.sv
module ofdm_ss_decoder
    import ofdm_timer_pkg::*;
#(
    parameter int SPS           = 14,
    parameter int SYM_PER_FRAME = 280,
    parameter int BLOCKS        = 8,
    parameter int BLK_SYMS      = 4,
    parameter int BUF_DEPTH     = 960,
    parameter int FS_W          = 9,
    parameter int IDX_W         = 3,
    parameter int ADDR_W        = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sym_adv,
    input  logic              frame_even_nxt,
    output logic              ss_active,
    output logic [IDX_W-1:0]  ss_idx,
    output logic [ADDR_W-1:0] buf_addr
);

    ss_state_e         state_q, state_n;
    logic [FS_W-1:0]   fsym_q, fsym_n;
    logic [BLOCKS-1:0] hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              any_hit;

    // Frame symbol number after this edge
    always_comb begin
        fsym_n = fsym_q;
        if (sym_adv) begin
            if (fsym_q == FS_W'(SYM_PER_FRAME - 1)) fsym_n = '0;
            else                                     fsym_n = fsym_q + 1'b1;
        end
    end

    // One window comparator per block position
    genvar k;
    generate
        for (k = 0; k < BLOCKS; k++) begin : g_win
            localparam int unsigned ST = blk_start(k, SPS);
            assign hit[k] = (32'(fsym_n) >= ST) && (32'(fsym_n) < ST + BLK_SYMS);
        end
    endgenerate

    assign any_hit = |hit;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < BLOCKS; i++) begin
            if (hit[i]) hit_idx = IDX_W'(i);
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SS_OFF_FRAME: begin
                if (frame_even_nxt) state_n = any_hit ? SS_BLOCK : SS_GAP;   // burst-frame entry
            end
            SS_GAP: begin
                if (!frame_even_nxt) state_n = SS_OFF_FRAME;                 // frame leave
                else if (any_hit)    state_n = SS_BLOCK;                     // block start
            end
            SS_BLOCK: begin
                if (!frame_even_nxt) state_n = SS_OFF_FRAME;                 // frame leave
                else if (!any_hit)   state_n = SS_GAP;                       // block end
            end
            default: state_n = SS_GAP;
        endcase
    end

    // State register (with the frame symbol tracker it walks on)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SS_GAP;
            fsym_q  <= '0;
        end else begin
            state_q <= state_n;
            fsym_q  <= fsym_n;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_idx   <= '0;
            buf_addr <= '0;
        end else if (state_n == SS_BLOCK) begin
            ss_idx <= hit_idx;
            if (state_q != SS_BLOCK || hit_idx != ss_idx) begin
                buf_addr <= '0;                                              // block start / next block
            end else if (en) begin
                if (buf_addr == ADDR_W'(BUF_DEPTH - 1)) buf_addr <= '0;
                else                                    buf_addr <= buf_addr + 1'b1;
            end
        end else begin
            ss_idx   <= '0;
            buf_addr <= '0;
        end
    end

    assign ss_active = (state_q == SS_BLOCK);

endmodule

// File: rtl/ofdm_frame_timer.sv
module ofdm_frame_timer #(
    parameter int SAMPLE_W   = 12,
    parameter int SPS        = 14,
    parameter int SLOTS      = 2,
    parameter int SFS        = 10,
    parameter int NUM_FRAMES = 1024,
    parameter int BLOCKS     = 8,
    parameter int BLK_SYMS   = 4,
    parameter int BUF_DEPTH  = 960,
    localparam int SYM_W         = $clog2(SPS),
    localparam int SLOT_W        = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int SF_W          = $clog2(SFS),
    localparam int FRAME_W       = $clog2(NUM_FRAMES),
    localparam int SYM_PER_FRAME = SPS * SLOTS * SFS,
    localparam int FS_W          = $clog2(SYM_PER_FRAME),
    localparam int IDX_W         = $clog2(BLOCKS),
    localparam int ADDR_W        = $clog2(BUF_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sym_len,
    output logic [SAMPLE_W-1:0] sample_idx,
    output logic [SYM_W-1:0]    sym_idx,
    output logic [SLOT_W-1:0]   slot_idx,
    output logic [SF_W-1:0]     subframe_idx,
    output logic [FRAME_W-1:0]  frame_idx,
    output logic                sym_tick,
    output logic                slot_tick,
    output logic                subframe_tick,
    output logic                frame_tick,
    output logic                first_sym,
    output logic                ss_active,
    output logic [IDX_W-1:0]    ss_idx,
    output logic [ADDR_W-1:0]   buf_addr
);

    logic [3:0] ticks;
    logic       sym_adv;
    logic       frame_even_nxt;

    ofdm_count_chain #(
        .SAMPLE_W   (SAMPLE_W),
        .SPS        (SPS),
        .SLOTS      (SLOTS),
        .SFS        (SFS),
        .NUM_FRAMES (NUM_FRAMES),
        .SYM_W      (SYM_W),
        .SLOT_W     (SLOT_W),
        .SF_W       (SF_W),
        .FRAME_W    (FRAME_W)
    ) u_chain (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .sym_len        (sym_len),
        .sample_cnt     (sample_idx),
        .sym_cnt        (sym_idx),
        .slot_cnt       (slot_idx),
        .sf_cnt         (subframe_idx),
        .frame_cnt      (frame_idx),
        .ticks          (ticks),
        .sym_adv        (sym_adv),
        .frame_even_nxt (frame_even_nxt)
    );

    ofdm_ss_decoder #(
        .SPS           (SPS),
        .SYM_PER_FRAME (SYM_PER_FRAME),
        .BLOCKS        (BLOCKS),
        .BLK_SYMS      (BLK_SYMS),
        .BUF_DEPTH     (BUF_DEPTH),
        .FS_W          (FS_W),
        .IDX_W         (IDX_W),
        .ADDR_W        (ADDR_W)
    ) u_ss (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .sym_adv        (sym_adv),
        .frame_even_nxt (frame_even_nxt),
        .ss_active      (ss_active),
        .ss_idx         (ss_idx),
        .buf_addr       (buf_addr)
    );

    assign sym_tick      = ticks[0];
    assign slot_tick     = ticks[1];
    assign subframe_tick = ticks[2];
    assign frame_tick    = ticks[3];
    assign first_sym     = (sym_idx == '0);

endmodule

// File: rtl/ofdm_frame_timer_chk.sv
module ofdm_frame_timer_chk #(
    parameter int SAMPLE_W  = 12,
    parameter int SPS       = 14,
    parameter int SLOTS     = 2,
    parameter int SFS       = 10,
    parameter int BUF_DEPTH = 960,
    parameter int SYM_W     = 4,
    parameter int SLOT_W    = 1,
    parameter int SF_W      = 4,
    parameter int FRAME_W   = 10,
    parameter int IDX_W     = 3,
    parameter int ADDR_W    = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic [SAMPLE_W-1:0] sample_idx,
    input logic [SYM_W-1:0]    sym_idx,
    input logic [SLOT_W-1:0]   slot_idx,
    input logic [SF_W-1:0]     subframe_idx,
    input logic [FRAME_W-1:0]  frame_idx,
    input logic                sym_tick,
    input logic                slot_tick,
    input logic                subframe_tick,
    input logic                frame_tick,
    input logic                first_sym,
    input logic                ss_active,
    input logic [IDX_W-1:0]    ss_idx,
    input logic [ADDR_W-1:0]   buf_addr
);

    assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sym_idx) < SPS) && (32'(slot_idx) < SLOTS) && (32'(subframe_idx) < SFS));

    assert_sym_tick_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_tick |-> (sample_idx == '0));

    assert_slot_tick_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |-> (sym_tick && sym_idx == '0));

    assert_sf_tick_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        subframe_tick |-> (slot_tick && slot_idx == '0));

    assert_frame_tick_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> (subframe_tick && subframe_idx == '0));

    assert_first_on_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |-> first_sym);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(sample_idx) && $stable(sym_idx) && $stable(frame_idx)
                 && $stable(buf_addr) && $stable(ss_active) && !sym_tick));

    assert_burst_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> (frame_idx[0] == 1'b0));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_active |-> (ss_idx == '0 && buf_addr == '0));

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ss_active) |=> (!ss_active || ss_idx != $past(ss_idx)
            || buf_addr == (($past(buf_addr) == ADDR_W'(BUF_DEPTH - 1)) ? '0 : $past(buf_addr) + 1'b1)));

endmodule

bind ofdm_frame_timer ofdm_frame_timer_chk #(
    .SAMPLE_W  (SAMPLE_W),
    .SPS       (SPS),
    .SLOTS     (SLOTS),
    .SFS       (SFS),
    .BUF_DEPTH (BUF_DEPTH),
    .SYM_W     (SYM_W),
    .SLOT_W    (SLOT_W),
    .SF_W      (SF_W),
    .FRAME_W   (FRAME_W),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .sample_idx    (sample_idx),
    .sym_idx       (sym_idx),
    .slot_idx      (slot_idx),
    .subframe_idx  (subframe_idx),
    .frame_idx     (frame_idx),
    .sym_tick      (sym_tick),
    .slot_tick     (slot_tick),
    .subframe_tick (subframe_tick),
    .frame_tick    (frame_tick),
    .first_sym     (first_sym),
    .ss_active     (ss_active),
    .ss_idx        (ss_idx),
    .buf_addr      (buf_addr)
);

// File: tb/ofdm_frame_timer_test.sv
module ofdm_frame_timer_test;

    localparam int PERIOD = 10;
    localparam int NF     = 4;
    localparam int SL     = 4;
    localparam int NVEC   = 20;

    // {enabled cycles since reset, ss_active, ss_idx, buf_addr}
    localparam int VEC [NVEC][4] = '{
        '{0,    0, 0, 0},
        '{16,   1, 0, 0},
        '{28,   1, 0, 12},
        '{31,   1, 0, 15},
        '{32,   1, 1, 0},
        '{48,   0, 0, 0},
        '{56,   0, 0, 0},
        '{64,   1, 2, 0},
        '{84,   1, 3, 4},
        '{112,  0, 0, 0},
        '{130,  1, 4, 2},
        '{150,  1, 5, 6},
        '{177,  1, 6, 1},
        '{207,  1, 7, 15},
        '{208,  0, 0, 0},
        '{1120, 0, 0, 0},
        '{1136, 0, 0, 0},
        '{2368, 1, 4, 0},
        '{4480, 0, 0, 0},
        '{4496, 1, 0, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [11:0] sym_len = 12'(SL);
    logic [11:0] sample_idx;
    logic [3:0]  sym_idx;
    logic [0:0]  slot_idx;
    logic [3:0]  subframe_idx;
    logic [1:0]  frame_idx;
    logic        sym_tick, slot_tick, subframe_tick, frame_tick, first_sym, ss_active;
    logic [2:0]  ss_idx;
    logic [9:0]  buf_addr;

    int checks = 0;
    int fails  = 0;
    int n      = 0;

    always #(PERIOD / 2) clk = ~clk;

    ofdm_frame_timer #(.NUM_FRAMES(NF)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .sym_len(sym_len),
        .sample_idx(sample_idx), .sym_idx(sym_idx), .slot_idx(slot_idx),
        .subframe_idx(subframe_idx), .frame_idx(frame_idx),
        .sym_tick(sym_tick), .slot_tick(slot_tick), .subframe_tick(subframe_tick),
        .frame_tick(frame_tick), .first_sym(first_sym), .ss_active(ss_active),
        .ss_idx(ss_idx), .buf_addr(buf_addr)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic advance_to(input int target);
        while (n < target) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Index and strobe model for n enabled cycles with symbol length len
    task automatic check_timing(input int cyc, input int len);
        int total, fsym, smp, sy, sl, sf, fr;
        int e_st, e_slt, e_sft, e_frt;
        total = cyc / len;
        smp   = cyc % len;
        fsym  = total % 280;
        fr    = (total / 280) % NF;
        sy    = fsym % 14;
        sl    = (fsym / 14) % 2;
        sf    = fsym / 28;
        e_st  = (cyc > 0 && smp == 0) ? 1 : 0;
        e_slt = (e_st == 1 && sy == 0) ? 1 : 0;
        e_sft = (e_slt == 1 && sl == 0) ? 1 : 0;
        e_frt = (e_sft == 1 && sf == 0) ? 1 : 0;
        chk("R2 sample_idx", int'(sample_idx), smp);
        chk("R3 sym_idx", int'(sym_idx), sy);
        chk("R3 slot_idx", int'(slot_idx), sl);
        chk("R3 subframe_idx", int'(subframe_idx), sf);
        chk("R3 frame_idx", int'(frame_idx), fr);
        chk("R4 sym_tick", int'(sym_tick), e_st);
        chk("R4 slot_tick", int'(slot_tick), e_slt);
        chk("R4 subframe_tick", int'(subframe_tick), e_sft);
        chk("R4 frame_tick", int'(frame_tick), e_frt);
        chk("R5 first_sym", int'(first_sym), (sy == 0) ? 1 : 0);
    endtask

    task automatic check_ss(input int act, input int idx, input int addr);
        chk("R7 ss_active", int'(ss_active), act);
        chk("R8 ss_idx", int'(ss_idx), idx);
        chk("R9 buf_addr", int'(buf_addr), addr);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state, reset released with enable low
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_timing(0, SL);
        check_ss(0, 0, 0);
        en = 1'b1;
        n  = 0;

        // Table walk over one burst, odd frame, and the frame wrap (R2-R9)
        for (int v = 0; v < NVEC; v++) begin
            advance_to(VEC[v][0]);
            check_timing(n, SL);
            check_ss(VEC[v][1], VEC[v][2], VEC[v][3]);
        end

        // R6: freeze inside block 0 right after a symbol boundary
        en = 1'b0;
        repeat (5) @(negedge clk);
        chk("R6 sample_idx held", int'(sample_idx), 0);
        chk("R6 sym_idx held", int'(sym_idx), 4);
        chk("R6 sym_tick low", int'(sym_tick), 0);
        chk("R6 buf_addr held", int'(buf_addr), 0);
        chk("R6 ss_active held", int'(ss_active), 1);
        en = 1'b1;
        advance_to(4499);
        check_timing(n, SL);
        check_ss(1, 0, 3);

        // R1 again: reset mid-run, then full-length symbols (sym_len = 0)
        rst_n   = 1'b0;
        sym_len = 12'd0;
        @(negedge clk);
        check_timing(0, 4096);
        check_ss(0, 0, 0);
        rst_n = 1'b1;
        n     = 0;
        advance_to(4095);
        chk("R2 full length last sample", int'(sample_idx), 4095);
        chk("R2 full length sym", int'(sym_idx), 0);
        advance_to(4096);
        check_timing(n, 4096);
        advance_to(16384);
        check_timing(n, 4096);
        check_ss(1, 0, 0);
        advance_to(16384 + 959);
        check_ss(1, 0, 959);
        advance_to(16384 + 960);
        check_ss(1, 0, 0);  // R9 wrap at 960
        advance_to(16384 + 961);
        check_ss(1, 0, 1);

        summary();
    end

endmodule